// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block lets a synchronous design act as a 16-bit asynchronous static memory. It has active-low controls: a write strobe, a read output enable and one chip select per byte. A fast system clock samples these controls, the address and the input data bus, each through a two-stage synchronizer. The sampled values decide whether a read, a write or no access is in progress. For reads, the block drives each byte lane of a split data bus, an output value with a per-lane drive enable. Otherwise that lane is left undriven.

A write starts when the write strobe and at least one byte select are low. The lanes selected at that moment are latched. The write is committed to the internal word array at the first release of the strobe or of a latched byte select. The block also watches the bus protocol. If the address moves during a write, or an access starts too soon after the write strobe is released, it raises a sticky error flag.

Timing, as seen at the ports: pins sampled on clock edge t reach the decoder after edge t+1, and the lane outputs change on edge t+2. A read at the ports therefore lags its pins by three rising edges. The memory depth is 2^ADDR_W words. A full-size part uses 17 address bits; the default here is 10.

Top module: `bytelane_sram_emu`

## Requirements
- R1: A read is decoded when the sampled write strobe is high, the output enable is low and at least one byte select is low. `dq_oe[1]` (bits 15:8) is set exactly when the upper select is low, and `dq_oe[0]` (bits 7:0) exactly when the lower select is low. Both change two clock edges after the edge that samples the pins.
- R2: A lane with its enable set drives the stored byte of the addressed word. A lane with its enable clear drives zero on its `dq_out` bits.
- R3: When the output enable and the write strobe are both high, or both byte selects are high, both lane enables are low.
- R4: While the write strobe is low, no lane is driven, whatever the output enable is.
- R5: A write begins when the write strobe and at least one byte select are low. The output enable has no effect on it. The selected lanes and the address are latched at that start.
- R6: A write ends at the first rising of the write strobe or of a latched byte select. At that point it commits only the latched lanes at the start address. The other byte of the word keeps its stored value.
- R7: The committed data is the input bus value sampled together with the last still-active controls. A data change that arrives together with the terminating edge is not stored.
- R8: After a write ends, no new write begins until the write strobe goes high or both byte selects go high.
- R9: If the address changes while a write is active, `err_addr` sets and stays set until reset. The commit still uses the address latched at the start.
- R10: Measure the gap in clocks from the sampled rising of the write strobe to the start of a new read or write. If the gap is less than RECOV_CLKS, `err_recov` sets and stays set until reset. A gap of exactly RECOV_CLKS does not set it.
- R11: A read of the address being committed, sampled in the commit cycle itself, returns the newly written bytes.
- R12: Under reset, `dq_oe`, `dq_out`, `err_addr` and `err_recov` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_hi_n | input | 1 | Upper byte select, active low |
| ce_lo_n | input | 1 | Lower byte select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Input half of the data bus |
| dq_out | output | 16 | Output half of the data bus |
| dq_oe | output | 2 | Per-lane drive enable, bit 1 = upper byte |
| err_addr | output | 1 | Sticky flag: address moved during a write |
| err_recov | output | 1 | Sticky flag: access started too soon after a write |

## Verification
The interesting collision is a write that ends in the same sampled cycle as a read begins. This happens when the write strobe rises while the output enable and both byte selects stay low. In that one cycle the write commits, the output register loads the read, and the recovery monitor sees a start with a zero gap.

The bench provokes this on purpose at a fresh address. Its behavioural model orders the same edge as commit first, then read, then recovery judgment. It then compares the lane data, the lane enables and `err_recov` every clock against that model.

// File: rtl/bsram_pkg.sv
// Shared constants and types for the byte-lane SRAM emulator.
// Assumes a fixed two-lane, 8-bit-per-lane data bus.
package bsram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_ACTIVE = 2'd1,
        WS_DRAIN  = 2'd2
    } wr_state_t;
endpackage

// File: rtl/bsram_sync2.sv
// Two-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the bundle's bits are used together after both stages; no
// multi-bit coherence is promised beyond what the pin timing gives.
module bsram_sync2 #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bsram_lane_mem.sv
// Word store split into independent byte lanes with a write-through read.
// Assumes one write and one read address per cycle; a read of the word
// being written returns the new byte for the written lanes.
module bsram_lane_mem
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];
        logic              hit;

        // Store this lane's byte when the commit selects it.
        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                arr[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Read with forwarding of a same-cycle commit.
        always_comb begin
            hit = wr_en[g] && (waddr == raddr);
            rdata[g*LANE_W +: LANE_W] = hit ? wdata[g*LANE_W +: LANE_W]
                                            : arr[raddr];
        end
    end
endmodule

// File: rtl/bsram_wr_ctl.sv
// Write-cycle tracker: latches lanes, address and data at write start,
// finds the first release among the strobe and the latched selects,
// and issues a one-cycle commit. Assumes inputs are already synchronized.
module bsram_wr_ctl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cond,
    input  logic              we_n_s,
    input  logic [LANES-1:0]  ce_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output logic              wr_start,
    output logic              commit,
    output logic [LANES-1:0]  cm_lanes,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data,
    output logic              addr_err
);
    wr_state_t         st;
    logic [LANES-1:0]  lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              end_now;

    // Decode start, end and address drift from the current state.
    always_comb begin
        end_now  = we_n_s || |(lane_q & ce_n_s);
        wr_start = (st == WS_IDLE) && wr_cond;
        commit   = (st == WS_ACTIVE) && end_now;
        addr_err = (st == WS_ACTIVE) && !end_now && (addr_s != addr_q);
        cm_lanes = commit ? lane_q : '0;
        cm_addr  = addr_q;
        cm_data  = data_q;
    end

    // Advance the write state and hold the write's lanes, address, data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= WS_IDLE;
            lane_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            unique case (st)
                WS_IDLE: if (wr_cond) begin
                    st     <= WS_ACTIVE;
                    lane_q <= ~ce_n_s;
                    addr_q <= addr_s;
                    data_q <= din_s;
                end
                WS_ACTIVE: if (end_now) begin
                    st <= wr_cond ? WS_DRAIN : WS_IDLE;
                end else begin
                    data_q <= din_s;
                end
                WS_DRAIN: if (!wr_cond) begin
                    st <= WS_IDLE;
                end
                default: st <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bsram_recov.sv
// Recovery-time monitor: counts clocks since the write strobe rose and
// flags any cycle start that arrives before RECOV_CLKS have passed.
// Assumes a synchronized strobe; the count saturates at RECOV_CLKS.
module bsram_recov #(
    parameter int RECOV_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n_s,
    input  logic start,
    output logic viol
);
    localparam int CW = $clog2(RECOV_CLKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RECOV_CLKS);

    logic          we_prev;
    logic [CW-1:0] cnt;
    logic          rise;

    // Detect the strobe release and judge the gap at a start.
    always_comb begin
        rise = we_n_s && !we_prev;
        viol = start && (rise || (cnt < LIMIT));
    end

    // Track the strobe and count the clocks since its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_prev <= 1'b1;
            cnt     <= LIMIT;
        end else begin
            we_prev <= we_n_s;
            if (rise) begin
                cnt <= CW'(1);
            end else if (cnt < LIMIT) begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/bytelane_sram_emu.sv
// Top of the byte-lane asynchronous SRAM emulator. Synchronizes the
// pins, decodes read/write/idle, drives the lanes from registers and
// keeps the sticky protocol flags. Assumes clk is much faster than
// the pin activity so that every pin level lasts several clocks.
module bytelane_sram_emu
    import bsram_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int RECOV_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_hi_n,
    input  logic              ce_lo_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              err_addr,
    output logic              err_recov
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [3:0]        ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic              s_ceh, s_cel, s_we, s_oe;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;
    logic [LANES-1:0]  sel;
    logic              wr_cond, rd_cond, rd_prev, rd_start;
    logic              wr_start, commit, addr_err_set, viol;
    logic [LANES-1:0]  cm_lanes;
    logic [ADDR_W-1:0] cm_addr;
    logic [DATA_W-1:0] cm_data, rd_word;

    bsram_sync2 #(.W(4), .RST_VAL(4'hF)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ce_hi_n, ce_lo_n, we_n, oe_n}), .q(ctl_s)
    );

    bsram_sync2 #(.W(BUS_W), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d({addr, dq_in}), .q(bus_s)
    );

    // Split the synchronized bundles and decode the cycle type.
    always_comb begin
        {s_ceh, s_cel, s_we, s_oe} = ctl_s;
        {s_addr, s_din}            = bus_s;
        sel      = ~{s_ceh, s_cel};
        wr_cond  = !s_we && |sel;
        rd_cond  = s_we && !s_oe && |sel;
        rd_start = rd_cond && !rd_prev;
    end

    bsram_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_cond(wr_cond), .we_n_s(s_we),
        .ce_n_s({s_ceh, s_cel}), .addr_s(s_addr), .din_s(s_din),
        .wr_start(wr_start), .commit(commit), .cm_lanes(cm_lanes),
        .cm_addr(cm_addr), .cm_data(cm_data), .addr_err(addr_err_set)
    );

    bsram_lane_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_en(cm_lanes), .waddr(cm_addr), .wdata(cm_data),
        .raddr(s_addr), .rdata(rd_word)
    );

    bsram_recov #(.RECOV_CLKS(RECOV_CLKS)) u_recov (
        .clk(clk), .rst_n(rst_n), .we_n_s(s_we),
        .start(wr_start || rd_start), .viol(viol)
    );

    // Register lane enables, lane data and the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe     <= '0;
            dq_out    <= '0;
            rd_prev   <= 1'b0;
            err_addr  <= 1'b0;
            err_recov <= 1'b0;
        end else begin
            rd_prev   <= rd_cond;
            dq_oe     <= rd_cond ? sel : '0;
            err_addr  <= err_addr || addr_err_set;
            err_recov <= err_recov || viol;
            for (int g = 0; g < LANES; g++) begin
                dq_out[g*LANE_W +: LANE_W] <= (rd_cond && sel[g])
                    ? rd_word[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/bsram_chk.sv
// Protocol checker bound to the emulator top; observes ports only.
// Assumes the fixed pin-to-lane latency of three sampled edges.
module bsram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_hi_n,
    input logic        ce_lo_n,
    input logic        we_n,
    input logic        oe_n,
    input logic [15:0] dq_out,
    input logic [1:0]  dq_oe,
    input logic        err_addr,
    input logic        err_recov
);
    logic [1:0] age;
    logic       warm;

    // Count edges since reset so history lookups stay in range.
    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign warm = (age == 2'd3);

    // R1
    upper_lane_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && dq_oe[1]) |-> (!$past(ce_hi_n, 3) && $past(we_n, 3) && !$past(oe_n, 3)));

    // R1
    lower_lane_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && dq_oe[0]) |-> (!$past(ce_lo_n, 3) && $past(we_n, 3) && !$past(oe_n, 3)));

    // R3
    both_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(ce_hi_n, 3) && $past(ce_lo_n, 3)) |-> (dq_oe == 2'b00));

    // R4
    write_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(we_n, 3)) |-> (dq_oe == 2'b00));

    // R2
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe[0] |-> (dq_out[7:0] == 8'h00));

    // R2
    idle_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe[1] |-> (dq_out[15:8] == 8'h00));

    // R9
    addr_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr |=> err_addr);

    // R10
    recov_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_recov |=> err_recov);
endmodule

bind bytelane_sram_emu bsram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_hi_n(ce_hi_n), .ce_lo_n(ce_lo_n),
    .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .err_addr(err_addr), .err_recov(err_recov)
);

// File: tb/test_bytelane_sram_emu.sv
// Bench: behavioural per-clock model compared with the ports each cycle.
module test_bytelane_sram_emu;
    localparam int CLK_NS = 10;
    localparam int AW     = 10;
    localparam int RC     = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_hi_n, ce_lo_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [15:0]   dq_in;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;
    logic          err_addr, err_recov;

    bytelane_sram_emu #(.ADDR_W(AW), .RECOV_CLKS(RC)) i_bytelane_sram_emu (
        .clk(clk), .rst_n(rst_n), .ce_hi_n(ce_hi_n), .ce_lo_n(ce_lo_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .err_addr(err_addr), .err_recov(err_recov)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct {
        bit      h, l, w, o;
        int      a;
        bit [15:0] d;
    } pins_t;

    int    n_vec = 0, n_bad = 0;
    bit    done  = 0;
    string cur_req = "R12";

    pins_t s1, s2;
    bit [7:0] m_hi [int];
    bit [7:0] m_lo [int];
    int       m_st, m_waddr, m_cnt;
    bit [1:0] m_mask;
    bit [15:0] m_wdata;
    bit       m_weprev, m_rcprev, m_ea, m_er;
    bit [1:0] exp_oe;
    bit [15:0] exp_do;
    bit [1:0] exp_known;

    function automatic pins_t idle_pins();
        pins_t p;
        p.h = 1; p.l = 1; p.w = 1; p.o = 1; p.a = 0; p.d = 16'h0;
        return p;
    endfunction

    function automatic void model_reset();
        s1 = idle_pins(); s2 = idle_pins();
        m_st = 0; m_waddr = 0; m_cnt = RC; m_mask = 0; m_wdata = 0;
        m_weprev = 1; m_rcprev = 0; m_ea = 0; m_er = 0;
        exp_oe = 0; exp_do = 0; exp_known = 0;
    endfunction

    function automatic void model_edge();
        pins_t S = s2;
        bit wc   = !S.w && (!S.h || !S.l);
        bit rc   = S.w && !S.o && (!S.h || !S.l);
        bit rise = S.w && !m_weprev;
        bit wst  = 0;
        bit endn;
        if (m_st == 0) begin
            if (wc) begin
                m_mask = {!S.h, !S.l}; m_waddr = S.a; m_wdata = S.d;
                m_st = 1; wst = 1;
            end
        end else if (m_st == 1) begin
            endn = S.w || (m_mask[1] && S.h) || (m_mask[0] && S.l);
            if (endn) begin
                if (m_mask[1]) m_hi[m_waddr] = m_wdata[15:8];
                if (m_mask[0]) m_lo[m_waddr] = m_wdata[7:0];
                m_st = wc ? 2 : 0;
            end else begin
                if (S.a != m_waddr) m_ea = 1;
                m_wdata = S.d;
            end
        end else if (!wc) begin
            m_st = 0;
        end
        if ((wst || (rc && !m_rcprev)) && (rise || m_cnt < RC)) m_er = 1;
        m_cnt = rise ? 1 : ((m_cnt < RC) ? m_cnt + 1 : m_cnt);
        m_weprev = S.w; m_rcprev = rc;
        exp_oe = rc ? {!S.h, !S.l} : 2'b00;
        exp_do = 0; exp_known = 2'b11;
        if (exp_oe[1]) begin
            if (m_hi.exists(S.a)) exp_do[15:8] = m_hi[S.a]; else exp_known[1] = 0;
        end
        if (exp_oe[0]) begin
            if (m_lo.exists(S.a)) exp_do[7:0] = m_lo[S.a]; else exp_known[0] = 0;
        end
        s2 = s1;
        s1.h = ce_hi_n; s1.l = ce_lo_n; s1.w = we_n; s1.o = oe_n;
        s1.a = int'(addr); s1.d = dq_in;
    endfunction

    task automatic compare();
        bit bad = 0;
        n_vec++;
        if (dq_oe !== exp_oe) begin
            bad = 1;
            $display("FAIL %s lane enable: got %b exp %b", cur_req, dq_oe, exp_oe);
        end
        if (exp_known[1] && dq_out[15:8] !== exp_do[15:8]) begin
            bad = 1;
            $display("FAIL %s upper byte: got %h exp %h", cur_req, dq_out[15:8], exp_do[15:8]);
        end
        if (exp_known[0] && dq_out[7:0] !== exp_do[7:0]) begin
            bad = 1;
            $display("FAIL %s lower byte: got %h exp %h", cur_req, dq_out[7:0], exp_do[7:0]);
        end
        if (err_addr !== m_ea) begin
            bad = 1;
            $display("FAIL %s err_addr: got %b exp %b", cur_req, err_addr, m_ea);
        end
        if (err_recov !== m_er) begin
            bad = 1;
            $display("FAIL %s err_recov: got %b exp %b", cur_req, err_recov, m_er);
        end
        if (bad) n_bad++;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (!rst_n) model_reset(); else model_edge();
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic drive(input bit h, input bit l, input bit w, input bit o,
                         input int a, input bit [15:0] d);
        ce_hi_n = h; ce_lo_n = l; we_n = w; oe_n = o;
        addr = AW'(a); dq_in = d;
    endtask

    task automatic idle(input int n);
        drive(1, 1, 1, 1, 0, 16'h0);
        run(n);
    endtask

    initial begin
        rst_n = 0;
        drive(1, 1, 1, 1, 0, 16'h0);
        cur_req = "R12";
        run(3);
        rst_n = 1;
        run(2);

        // Full write with output enable low: output enable ignored.
        cur_req = "R5";
        drive(0, 0, 0, 0, 5, 16'hA1B2); run(3);
        cur_req = "R6";
        drive(0, 0, 1, 1, 5, 16'hA1B2); run(1);
        idle(6);

        // Reads: full word, upper only, lower only.
        cur_req = "R1";
        drive(0, 0, 1, 0, 5, 16'h0); run(4); idle(5);
        drive(0, 1, 1, 0, 5, 16'h0); run(4); idle(5);
        cur_req = "R2";
        drive(1, 0, 1, 0, 5, 16'h0); run(4); idle(5);

        // Upper-only write keeps the lower byte.
        cur_req = "R6";
        drive(0, 1, 0, 1, 5, 16'h7700); run(3); idle(6);
        drive(0, 0, 1, 0, 5, 16'h0); run(4); idle(5);

        // End by a select rising first, then hold the strobe low.
        drive(0, 0, 0, 1, 9, 16'h1234); run(3);
        drive(1, 0, 0, 1, 9, 16'h1234); run(1);
        cur_req = "R8";
        drive(1, 0, 0, 1, 9, 16'hFFFF); run(3); idle(6);
        drive(0, 0, 1, 0, 9, 16'h0); run(4); idle(5);

        // Data changed together with the terminating edge is dropped.
        cur_req = "R7";
        drive(0, 0, 0, 1, 12, 16'h1111); run(2);
        drive(0, 0, 0, 1, 12, 16'h2222); run(1);
        drive(0, 0, 1, 1, 12, 16'h3333); run(1); idle(6);
        drive(0, 0, 1, 0, 12, 16'h0); run(4); idle(5);

        // Output disabled cases.
        cur_req = "R3";
        drive(0, 0, 1, 1, 12, 16'h0); run(4);
        drive(1, 1, 1, 0, 12, 16'h0); run(4); idle(5);

        // Strobe low with output enable low drives nothing.
        cur_req = "R4";
        drive(0, 0, 0, 0, 12, 16'h5A5A); run(4);
        drive(0, 0, 1, 1, 12, 16'h5A5A); run(1); idle(6);
        drive(0, 0, 1, 0, 12, 16'h0); run(4); idle(5);

        // Address drift during a write.
        cur_req = "R9";
        drive(0, 0, 0, 1, 20, 16'hBEEF); run(2);
        drive(0, 0, 0, 1, 21, 16'hBEEF); run(2);
        drive(1, 1, 1, 1, 21, 16'h0); run(6);
        drive(0, 0, 1, 0, 20, 16'h0); run(4); idle(5);

        // Recovery: exact limit passes, short gap flags.
        cur_req = "R10";
        drive(0, 0, 0, 1, 30, 16'h0F0F); run(2);
        idle(RC);
        drive(0, 0, 1, 0, 30, 16'h0); run(3); idle(5);
        drive(0, 0, 0, 1, 31, 16'h0001); run(2);
        idle(2);
        drive(0, 0, 1, 0, 31, 16'h0); run(4); idle(5);

        // Read starting in the commit cycle sees new data.
        cur_req = "R11";
        drive(0, 0, 0, 0, 40, 16'hC3C3); run(3);
        drive(0, 0, 1, 0, 40, 16'h0); run(4); idle(5);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule